// File: doc/BRIEF.md
# File-Register Rotate Execution Unit

This block executes two byte-wide rotate instructions of a small accumulator-style microcontroller core: a rotate left that wraps the top bit into the bottom bit, and a rotate right through the carry flag. It takes a 16-bit instruction word with a valid strobe and decodes it. It then forms a 12-bit data-memory address, either from a fixed access window or from a 4-bit bank select value. It reads the addressed byte through a synchronous register-file port and computes the rotated byte. The result goes either to the internal working register or back to the same file location, and the carry, negative and zero flags are updated.

Each accepted instruction runs through four phases of one clock cycle each: decode, read, process, write. The unit accepts a new instruction only when it is idle. An instruction word that is neither of the two rotates is dropped after the decode phase and flagged on a one-cycle illegal-op output. The bank select value is sampled during decode and must stay valid until then. The register file answers a read strobe with data in the following cycle.

Top module: `filerot_unit`

## Requirements
- R1: Bits [15:10] = 6'b010001 select rotate-left-no-carry and 6'b001100 select rotate-right-through-carry; bit 9 is the destination bit d, bit 8 the bank bit a, bits [7:0] the file address f.
- R2: With a=1 the data address is {bsr_i, f}; with a=0 it is {4'h0, f} for f < 8'h60 and {4'hF, f} for f >= 8'h60.
- R3: Rotate left gives {x[6:0], x[7]}; N (status bit 2) = result bit 7, Z (status bit 1) = result is zero, and C (status bit 0) is left unchanged.
- R4: Rotate right through carry gives {C, x[7:1]} and the new C is old x[0]; N and Z are set as in R3.
- R5: With d=0 the result is written to W and no file write occurs; with d=1 exactly one file write of the result occurs and W is unchanged.
- R6: After acceptance, busy_o is high for four cycles; the read strobe is high for exactly the second cycle and the write strobe only in the fourth; W and status change at the end of the fourth.
- R7: An unrecognised instruction word makes no read, no write and no change to W or status, and drives illegal_op_o high for exactly one cycle; busy_o is high for one cycle only.
- R8: After reset, W and status are zero, busy_o and illegal_op_o are low, and neither strobe is active.
- R9: A valid strobe arriving while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction strobe, taken only when idle |
| bsr_i | input | 4 | Bank select value |
| rf_addr_o | output | 12 | Register-file address |
| rf_rd_en_o | output | 1 | Read strobe; data returned the next cycle |
| rf_rdata_i | input | 8 | Read data |
| rf_wr_en_o | output | 1 | Write strobe |
| rf_wdata_o | output | 8 | Write data |
| w_o | output | 8 | Working register |
| status_o | output | 3 | Flags {N, Z, C} |
| busy_o | output | 1 | Instruction in progress |
| illegal_op_o | output | 1 | One-cycle pulse on an unrecognised word |

## Verification
Counted from the edge that accepts an instruction, the read strobe is due in the second busy cycle and the write strobe in the fourth. W, status and the written byte are visible once busy_o falls after four busy cycles. For an illegal word, busy_o falls after one cycle and the illegal pulse is high in that same cycle. The monitor samples on falling edges, counts busy cycles and records the cycle of each strobe. It compares all of them, together with the result, only at the falling edge where busy_o has just dropped, so every check lands on the cycle its result is due.

// File: rtl/filerot_pkg.sv
// Shared types for the file-register rotate unit.
// Assumes an 8-bit file address field and a 3-bit status register {N,Z,C}.
package filerot_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEC,
        PH_READ,
        PH_CALC,
        PH_WRITE
    } phase_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ROL,
        OP_RORC
    } op_t;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_W = 3;

    localparam logic [5:0] OPC_ROL  = 6'b010001;
    localparam logic [5:0] OPC_RORC = 6'b001100;

    typedef struct packed {
        op_t        op;
        logic       dest_file;
        logic       use_bank;
        logic [7:0] faddr;
    } dec_t;
endpackage

// File: rtl/filerot_decode.sv
// Instruction decoder: splits the word into opcode class, d, a and f.
// Assumes a 16-bit word whose top six bits carry the opcode.
module filerot_decode
    import filerot_pkg::*;
#(
    parameter int INSTR_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int OPC_LSB = INSTR_W - 6;

    // Classify the opcode and extract the operand fields.
    always_comb begin
        dec.dest_file = instr[9];
        dec.use_bank  = instr[8];
        dec.faddr     = instr[7:0];
        case (instr[INSTR_W-1:OPC_LSB])
            OPC_ROL:  dec.op = OP_ROL;
            OPC_RORC: dec.op = OP_RORC;
            default:  dec.op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/filerot_agen.sv
// Data address generator: bank-register form or split access window.
// Assumes the window's low part sits in bank 0 and its high part in the top bank.
module filerot_agen #(
    parameter int          FILE_W    = 8,
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h60
) (
    input  logic [FILE_W-1:0]        faddr,
    input  logic                     use_bank,
    input  logic [BANK_W-1:0]        bank,
    output logic [BANK_W+FILE_W-1:0] addr
);
    localparam logic [BANK_W-1:0] BANK_LO = '0;
    localparam logic [BANK_W-1:0] BANK_HI = '1;

    // Pick the bank half of the address.
    always_comb begin
        if (use_bank)
            addr = {bank, faddr};
        else if (faddr < FILE_W'(ACC_SPLIT))
            addr = {BANK_LO, faddr};
        else
            addr = {BANK_HI, faddr};
    end
endmodule

// File: rtl/filerot_alu.sv
// Rotate datapath: left without carry, or right through carry, plus N/Z.
// Assumes carry is passed through untouched for the left rotate.
module filerot_alu
    import filerot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_t               op,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output logic [DATA_W-1:0] dout,
    output logic              cout,
    output logic              neg,
    output logic              zero
);
    // Form the rotated value and the outgoing carry.
    always_comb begin
        case (op)
            OP_ROL: begin
                dout = {din[DATA_W-2:0], din[DATA_W-1]};
                cout = cin;
            end
            OP_RORC: begin
                dout = {cin, din[DATA_W-1:1]};
                cout = din[0];
            end
            default: begin
                dout = din;
                cout = cin;
            end
        endcase
    end

    // Derive the sign and zero flags from the result.
    always_comb begin
        neg  = dout[DATA_W-1];
        zero = (dout == '0);
    end
endmodule

// File: rtl/filerot_seq.sv
// Phase sequencer: idle, decode, read, process, write.
// Assumes a start request is only honoured while idle.
module filerot_seq
    import filerot_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   legal,
    output phase_t phase
);
    phase_t phase_nx;

    // Next-phase selection.
    always_comb begin
        case (phase)
            PH_IDLE:  phase_nx = start ? PH_DEC : PH_IDLE;
            PH_DEC:   phase_nx = legal ? PH_READ : PH_IDLE;
            PH_READ:  phase_nx = PH_CALC;
            PH_CALC:  phase_nx = PH_WRITE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end
endmodule

// File: rtl/filerot_unit.sv
// File-register rotate unit top: four-phase execution of two rotate opcodes.
// Assumes the register file returns read data one cycle after the read strobe
// and that bsr_i is valid in the decode phase.
module filerot_unit
    import filerot_pkg::*;
#(
    parameter int         INSTR_W   = 16,
    parameter int         DATA_W    = 8,
    parameter int         BANK_W    = 4,
    parameter logic [7:0] ACC_SPLIT = 8'h60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [INSTR_W-1:0]       instr_i,
    input  logic                     instr_valid_i,
    input  logic [BANK_W-1:0]        bsr_i,
    output logic [BANK_W+7:0]        rf_addr_o,
    output logic                     rf_rd_en_o,
    input  logic [DATA_W-1:0]        rf_rdata_i,
    output logic                     rf_wr_en_o,
    output logic [DATA_W-1:0]        rf_wdata_o,
    output logic [DATA_W-1:0]        w_o,
    output logic [FLAG_W-1:0]        status_o,
    output logic                     busy_o,
    output logic                     illegal_op_o
);
    localparam int ADDR_W = BANK_W + 8;

    phase_t               phase;
    logic [INSTR_W-1:0]   instr_q;
    dec_t                 dec;
    logic [ADDR_W-1:0]    addr_nx;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    alu_out;
    logic                 alu_cout, alu_neg, alu_zero;
    logic [DATA_W-1:0]    res_q;
    logic [FLAG_W-1:0]    flags_nx_q;
    logic                 illegal_q;
    logic                 start;

    assign start = instr_valid_i && (phase == PH_IDLE);

    filerot_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .legal (dec.op != OP_NONE),
        .phase (phase)
    );

    filerot_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr (instr_q),
        .dec   (dec)
    );

    filerot_agen #(.FILE_W(8), .BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_agen (
        .faddr    (dec.faddr),
        .use_bank (dec.use_bank),
        .bank     (bsr_i),
        .addr     (addr_nx)
    );

    filerot_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (dec.op),
        .din  (rf_rdata_i),
        .cin  (status_o[FLAG_C]),
        .dout (alu_out),
        .cout (alu_cout),
        .neg  (alu_neg),
        .zero (alu_zero)
    );

    // Capture the instruction word when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)     instr_q <= '0;
        else if (start) instr_q <= instr_i;
    end

    // Latch the data address during decode.
    always_ff @(posedge clk) begin
        if (!rst_n)                addr_q <= '0;
        else if (phase == PH_DEC)  addr_q <= addr_nx;
    end

    // Register the rotated byte and the pending flags during process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            flags_nx_q <= '0;
        end else if (phase == PH_CALC) begin
            res_q      <= alu_out;
            flags_nx_q <= {alu_neg, alu_zero, alu_cout};
        end
    end

    // Commit W and the flags at the end of the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_o      <= '0;
            status_o <= '0;
        end else if (phase == PH_WRITE) begin
            status_o <= flags_nx_q;
            if (!dec.dest_file) w_o <= res_q;
        end
    end

    // One-cycle illegal-op pulse after a failed decode.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= (phase == PH_DEC) && (dec.op == OP_NONE);
    end

    // Drive the register-file port and the status outputs.
    always_comb begin
        rf_addr_o    = addr_q;
        rf_rd_en_o   = (phase == PH_READ);
        rf_wr_en_o   = (phase == PH_WRITE) && dec.dest_file;
        rf_wdata_o   = res_q;
        busy_o       = (phase != PH_IDLE);
        illegal_op_o = illegal_q;
    end
endmodule

// File: rtl/filerot_checker.sv
// Protocol checker for filerot_unit, bound to every instance.
// Assumes rst_n is synchronous and active low.
module filerot_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              rf_rd_en_o,
    input logic              rf_wr_en_o,
    input logic              illegal_op_o,
    input logic [DATA_W-1:0] w_o,
    input logic [2:0]        status_o
);
    assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en_o |=> !rf_rd_en_o);

    assert_strobes_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd_en_o || rf_wr_en_o) |-> busy_o);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> !rf_rd_en_o);

    assert_w_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |=> $stable(w_o));

    assert_illegal_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op_o |=> !illegal_op_o);

    assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op_o |-> (!rf_rd_en_o && !rf_wr_en_o && $stable(w_o) && $stable(status_o)));
endmodule

bind filerot_unit filerot_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .rf_rd_en_o   (rf_rd_en_o),
    .rf_wr_en_o   (rf_wr_en_o),
    .illegal_op_o (illegal_op_o),
    .w_o          (w_o),
    .status_o     (status_o)
);

// File: tb/filerot_unit_test.sv
// Scoreboard bench for filerot_unit.
module filerot_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        valid = 1'b0;
    logic [3:0]  bsr = '0;
    logic [11:0] rf_addr;
    logic        rf_rd_en, rf_wr_en;
    logic [7:0]  rf_rdata = '0;
    logic [7:0]  rf_wdata;
    logic [7:0]  w;
    logic [2:0]  status;
    logic        busy, illegal;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    filerot_unit uut (
        .clk (clk), .rst_n (rst_n), .instr_i (instr), .instr_valid_i (valid),
        .bsr_i (bsr), .rf_addr_o (rf_addr), .rf_rd_en_o (rf_rd_en),
        .rf_rdata_i (rf_rdata), .rf_wr_en_o (rf_wr_en), .rf_wdata_o (rf_wdata),
        .w_o (w), .status_o (status), .busy_o (busy), .illegal_op_o (illegal)
    );

    // Register file model and an independent reference copy.
    logic [7:0] mem     [4096];
    logic [7:0] ref_mem [4096];
    logic [7:0] ref_w = '0;
    logic [2:0] ref_st = '0;

    always @(posedge clk) begin
        if (rf_rd_en) rf_rdata <= mem[rf_addr];
        if (rf_wr_en) mem[rf_addr] <= rf_wdata;
    end

    typedef struct {
        bit         legal;
        bit         dest_file;
        logic [11:0] addr;
        logic [7:0] w;
        logic [2:0] st;
        logic [7:0] memv;
        string      req;
    } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [7:0] v);
        mem[a] = v;
        ref_mem[a] = v;
    endtask

    function automatic logic [11:0] ref_addr(input logic [7:0] f, input bit a);
        if (a) return {bsr, f};
        return (f < 8'h60) ? {4'h0, f} : {4'hF, f};
    endfunction

    // Driver: compute expectation, push it, then present the word.
    task automatic run_op(input logic [15:0] word, input bit noise, input string req);
        exp_t e;
        logic [7:0] x, r;
        bit rol, rrc;
        rol = (word[15:10] == 6'b010001);
        rrc = (word[15:10] == 6'b001100);
        e.legal = rol || rrc;
        e.dest_file = word[9];
        e.addr = ref_addr(word[7:0], word[8]);
        e.req = req;
        if (e.legal) begin
            x = ref_mem[e.addr];
            if (rol) begin
                r = {x[6:0], x[7]};
            end else begin
                r = {ref_st[0], x[7:1]};
                ref_st[0] = x[0];
            end
            ref_st[2] = r[7];
            ref_st[1] = (r == 8'h00);
            if (word[9]) ref_mem[e.addr] = r;
            else         ref_w = r;
        end
        e.w = ref_w;
        e.st = ref_st;
        e.memv = ref_mem[e.addr];
        q.push_back(e);
        @(negedge clk);
        instr = word;
        valid = 1'b1;
        @(negedge clk);
        if (noise) begin
            instr = {6'b010001, 2'b01, 8'h00};
            repeat (3) @(negedge clk);
        end
        valid = 1'b0;
        instr = 16'hFFFF;
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: count busy cycles and strobes, compare when busy drops.
    int   cyc = 0, rds = 0, wrs = 0, rd_cyc = 0, wr_cyc = 0;
    logic [11:0] rd_addr = '0;
    bit   prev_busy = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; rds = 0; wrs = 0; prev_busy = 1'b0;
        end else begin
            if (busy) cyc++;
            if (rf_rd_en) begin rds++; rd_cyc = cyc; rd_addr = rf_addr; end
            if (rf_wr_en) begin wrs++; wr_cyc = cyc; end
            if (prev_busy && !busy && q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.legal) begin
                    chk(cyc == 4, "R6", "busy cycles", cyc, 4);
                    chk(rds == 1 && rd_cyc == 2, "R6", "read cycle", rd_cyc, 2);
                    chk(rd_addr == e.addr, {"R2 ", e.req}, "address", rd_addr, e.addr);
                    chk(wrs == int'(e.dest_file), "R5", "write count", wrs, int'(e.dest_file));
                    if (e.dest_file) chk(wr_cyc == 4, "R6", "write cycle", wr_cyc, 4);
                    chk(!illegal, "R7", "illegal on legal op", illegal, 0);
                end else begin
                    chk(cyc == 1, "R7", "busy cycles", cyc, 1);
                    chk(rds == 0 && wrs == 0, "R7", "strobes", rds + wrs, 0);
                    chk(illegal, "R7", "illegal pulse", illegal, 1);
                end
                chk(w == e.w, {"R5 ", e.req}, "W", w, e.w);
                chk(status == e.st, e.req, "status", status, e.st);
                chk(mem[e.addr] == e.memv, {"R5 ", e.req}, "file byte", mem[e.addr], e.memv);
                cyc = 0; rds = 0; wrs = 0;
            end
            prev_busy = busy;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus.
    initial begin
        logic [7:0] pats [7];
        logic [7:0] fs [4];
        pats = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hAB, 8'hE6, 8'h55};
        fs   = '{8'h5F, 8'h60, 8'h30, 8'hA5};
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'(i * 37 + 5);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk(w == 8'h00, "R8", "W after reset", w, 0);
        chk(status == 3'b000, "R8", "status after reset", status, 0);
        chk(!busy && !illegal, "R8", "busy/illegal", {busy, illegal}, 0);
        chk(!rf_rd_en && !rf_wr_en, "R8", "strobes", {rf_rd_en, rf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 worked example: AB -> 57 into the file.
        put(12'h025, 8'hAB);
        run_op({6'b010001, 2'b10, 8'h25}, 1'b0, "R1 R3");
        chk(mem[12'h025] == 8'h57, "R3", "example result", mem[12'h025], 8'h57);

        // R4 worked example: carry 0, E6 -> 73, carry 0, to W.
        put(12'h011, 8'h00);
        run_op({6'b001100, 2'b00, 8'h11}, 1'b0, "R4");
        put(12'h026, 8'hE6);
        run_op({6'b001100, 2'b00, 8'h26}, 1'b0, "R4");
        chk(w == 8'h73 && status[0] == 1'b0, "R4", "example result", w, 8'h73);

        // Sweep d, a, carry-in and patterns for both rotates.
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 2; a++)
                for (int c = 0; c < 2; c++)
                    for (int p = 0; p < 7; p++) begin
                        logic [7:0] f;
                        f = fs[(p + c) % 4];
                        bsr = 4'(p * 3 + d);
                        put(12'h010, {7'b0, 1'(c)});
                        run_op({6'b001100, 2'b00, 8'h10}, 1'b0, "R4");
                        put(ref_addr(f, 1'(a)), pats[p]);
                        run_op({6'b010001, 1'(d), 1'(a), f}, 1'b0, "R3");
                        put(ref_addr(f, 1'(a)), pats[p]);
                        run_op({6'b001100, 1'(d), 1'(a), f}, 1'b0, "R4");
                    end

        // R7: words that are not the two rotates.
        run_op(16'h4000 | 16'h0325, 1'b0, "R7");
        run_op({6'b001101, 2'b11, 8'h10}, 1'b0, "R7");
        run_op(16'hFFFF, 1'b0, "R7");
        run_op(16'h0000, 1'b0, "R7");

        // R9: valid held with another word while busy.
        put(12'h040, 8'h81);
        run_op({6'b001100, 2'b10, 8'h40}, 1'b1, "R9");
        put(12'h000, 8'h3C);
        run_op({6'b010001, 2'b00, 8'h41}, 1'b1, "R9");
        chk(mem[12'h000] == 8'h3C, "R9", "ignored write target", mem[12'h000], 8'h3C);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule